// File: doc/BRIEF.md
# Low-Voltage Detect Status and Control Register

This block is the 8-bit memory-mapped status and control register that sits beside a low-voltage detector in a microcontroller-style system. It samples the detector's low-voltage comparator output, gated by a detector enable, into a sticky flag. Software clears the flag by writing a one to an acknowledge bit. The flag is combined with two enable bits to form an interrupt request and a reset request for the system reset sequencer.

A third control bit, the safe-state enable, produces a wake-blocking qualifier. While the system is in stop mode and the supply is below the re-arm level, this qualifier holds off pending interrupt and reset wake sources. The safe-state enable and the reset enable are protected: after each reset, each of them accepts only one write. The reset enable comes up set after power-on and keeps its value through every other reset, including the reset it asks for itself.

Register writes carry a per-bit write mask, so each protected bit can be written, and therefore locked, on its own. The read data is combinational and always reflects the current register contents.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: Read data is {flag, 0, 0, 0, 0, int_en, safe_en, rst_en}, with bit 7 the flag and bits 2, 1, 0 the enables. Bits 6 to 3, which include the acknowledge position, always read 0.
- R2: At a clock edge with det_en_i = 1 and lv_det_i = 1, the flag becomes 1. It stays 1 until it is acknowledged or reset. With det_en_i = 0 the flag is never set.
- R3: A write with wmask_i[6] = 1 and wdata_i[6] = 1 clears the flag at that edge. If the set condition of R2 holds at the same edge, the flag stays 1.
- R4: Bit 2 (int_en) is freely read/write through masked writes. irq_o is 1 exactly when int_en and the flag are both 1.
- R5: rst_req_o is 1 exactly when rst_en and the flag are both 1.
- R6: Bit 1 (safe_en) and bit 0 (rst_en) each take only the first masked write to that bit after a reset; later writes to it are ignored. The lock is kept per bit, so writing one protected bit leaves the other writable.
- R7: Power-on reset (por_i = 1 at an edge) clears the flag, int_en and safe_en, sets rst_en to 1 and clears both write-once locks.
- R8: General reset (rst_i = 1 at an edge) clears the flag, int_en, safe_en and both locks, and leaves rst_en unchanged. When por_i and rst_i are both 1, power-on reset behaviour applies.
- R9: wake_blk_o = safe_en AND stop_i AND below_rearm_i. wake_o = wake_req_i AND NOT wake_blk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| rst_i | input | 1 | General system reset, synchronous, active high |
| lv_det_i | input | 1 | Low-voltage comparator output |
| det_en_i | input | 1 | Detector enable |
| below_rearm_i | input | 1 | Supply is below the re-arm level |
| stop_i | input | 1 | System is in stop mode |
| wake_req_i | input | 1 | Pending interrupt or reset wake source |
| wr_i | input | 1 | Register write strobe |
| wmask_i | input | 8 | Per-bit write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Low-voltage interrupt request |
| rst_req_o | output | 1 | Low-voltage reset request |
| wake_blk_o | output | 1 | Wake sources are being blocked |
| wake_o | output | 1 | Qualified wake request |

## Verification
The assertions assume that every input is a known value and is stable around each rising clock edge. They also assume that the resets are synchronous levels that the checks simply skip, so a property that spans a reset cycle is not evaluated. The stimulus drives all inputs only on the falling edge, from a fixed-seed generator. Resets are kept rare so that lock and flag histories grow long between them. The power-on reset is asserted from time zero, so no register is ever observed before it is initialised.

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg #(
  parameter int W        = 8,
  parameter int FLAG_BIT = 7,
  parameter int ACK_BIT  = 6,
  parameter int IE_BIT   = 2,
  parameter int SAFE_BIT = 1,
  parameter int RE_BIT   = 0
) (
  input  logic         clk_i,
  input  logic         por_i,
  input  logic         rst_i,
  input  logic         lv_det_i,
  input  logic         det_en_i,
  input  logic         below_rearm_i,
  input  logic         stop_i,
  input  logic         wake_req_i,
  input  logic         wr_i,
  input  logic [W-1:0] wmask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         irq_o,
  output logic         rst_req_o,
  output logic         wake_blk_o,
  output logic         wake_o
);

  logic flag_q, ie_q, safe_q, re_q;
  logic lk_safe_q, lk_re_q;

  wire set_c  = det_en_i & lv_det_i;
  wire ack_c  = wr_i & wmask_i[ACK_BIT] & wdata_i[ACK_BIT];
  wire wr_ie   = wr_i & wmask_i[IE_BIT];
  wire wr_safe = wr_i & wmask_i[SAFE_BIT] & ~lk_safe_q;
  wire wr_re   = wr_i & wmask_i[RE_BIT] & ~lk_re_q;

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      flag_q    <= 1'b0;
      ie_q      <= 1'b0;
      safe_q    <= 1'b0;
      re_q      <= 1'b1;
      lk_safe_q <= 1'b0;
      lk_re_q   <= 1'b0;
    end else if (rst_i) begin
      flag_q    <= 1'b0;
      ie_q      <= 1'b0;
      safe_q    <= 1'b0;
      lk_safe_q <= 1'b0;
      lk_re_q   <= 1'b0;
    end else begin
      if (set_c)      flag_q <= 1'b1;
      else if (ack_c) flag_q <= 1'b0;
      if (wr_ie) ie_q <= wdata_i[IE_BIT];
      if (wr_safe) begin
        safe_q    <= wdata_i[SAFE_BIT];
        lk_safe_q <= 1'b1;
      end
      if (wr_re) begin
        re_q    <= wdata_i[RE_BIT];
        lk_re_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[FLAG_BIT] = flag_q;
    rdata_o[IE_BIT]   = ie_q;
    rdata_o[SAFE_BIT] = safe_q;
    rdata_o[RE_BIT]   = re_q;
  end

  assign irq_o      = ie_q & flag_q;
  assign rst_req_o  = re_q & flag_q;
  assign wake_blk_o = safe_q & stop_i & below_rearm_i;
  assign wake_o     = wake_req_i & ~wake_blk_o;

  // R2
  flag_set_chk: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
    (det_en_i && lv_det_i) |=> rdata_o[FLAG_BIT]);

  // R2
  flag_no_spurious_chk: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
    (!rdata_o[FLAG_BIT] && !(det_en_i && lv_det_i)) |=> !rdata_o[FLAG_BIT]);

  // R3
  flag_ack_chk: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
    (wr_i && wmask_i[ACK_BIT] && wdata_i[ACK_BIT] && !(det_en_i && lv_det_i))
    |=> !rdata_o[FLAG_BIT]);

  // R6
  safe_once_chk: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
    (lk_safe_q && wr_i && wmask_i[SAFE_BIT]) |=> $stable(rdata_o[SAFE_BIT]));

  // R6
  re_once_chk: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
    (lk_re_q && wr_i && wmask_i[RE_BIT]) |=> $stable(rdata_o[RE_BIT]));

  // R7
  por_init_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    por_i |=> (rdata_o == W'(1) << RE_BIT));

  // R8
  rst_keeps_re_chk: assert property (@(posedge clk_i) disable iff (por_i)
    rst_i |=> ($stable(rdata_o[RE_BIT]) && !rdata_o[FLAG_BIT] && !irq_o));

  // R1
  zero_bits_chk: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
    rdata_o[ACK_BIT:IE_BIT+1] == '0);

endmodule

// File: tb/sim_lvd_ctrl_reg.sv
module sim_lvd_ctrl_reg;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic por = 1'b1, rst = 1'b0, lv = 1'b0, den = 1'b0, brm = 1'b0, stp = 1'b0, wrq = 1'b0, wr = 1'b0;
  logic [7:0] wm = '0, wd = '0;
  logic [7:0] rd;
  logic irq, rrq, blk, wk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic m_flag, m_ie, m_safe, m_re, m_lks, m_lkr;

  lvd_ctrl_reg u0 (
    .clk_i(clk), .por_i(por), .rst_i(rst), .lv_det_i(lv), .det_en_i(den),
    .below_rearm_i(brm), .stop_i(stp), .wake_req_i(wrq), .wr_i(wr),
    .wmask_i(wm), .wdata_i(wd), .rdata_o(rd), .irq_o(irq), .rst_req_o(rrq),
    .wake_blk_o(blk), .wake_o(wk)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_rd();
    return {m_flag, 4'b0000, m_ie, m_safe, m_re};
  endfunction

  function automatic logic exp_blk();
    return m_safe & stp & brm;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (por) begin
      m_flag = 0; m_ie = 0; m_safe = 0; m_re = 1; m_lks = 0; m_lkr = 0;
    end else if (rst) begin
      m_flag = 0; m_ie = 0; m_safe = 0; m_lks = 0; m_lkr = 0;
    end else begin
      if (den && lv) m_flag = 1;
      else if (wr && wm[6] && wd[6]) m_flag = 0;
      if (wr && wm[2]) m_ie = wd[2];
      if (wr && wm[1] && !m_lks) begin m_safe = wd[1]; m_lks = 1; end
      if (wr && wm[0] && !m_lkr) begin m_re = wd[0]; m_lkr = 1; end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R1 rdata", rd, exp_rd());
    chk("R4 irq", {7'b0, irq}, {7'b0, m_ie & m_flag});
    chk("R5 rst_req", {7'b0, rrq}, {7'b0, m_re & m_flag});
    chk("R9 wake_blk", {7'b0, blk}, {7'b0, exp_blk()});
    chk("R9 wake", {7'b0, wk}, {7'b0, wrq & ~exp_blk()});
  endtask

  task automatic idle();
    por = 0; rst = 0; wr = 0; wm = '0; wd = '0; lv = 0; den = 0;
  endtask

  task automatic wreg(input logic [7:0] m, input logic [7:0] d);
    wr = 1; wm = m; wd = d; tick(); wr = 0; wm = '0; wd = '0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    tick();
    idle(); tick();
    chk("R7 power-on value", rd, 8'h01);
    wreg(8'h01, 8'h00);
    chk("R6 first write to rst_en", rd, 8'h00);
    wreg(8'h01, 8'h01);
    chk("R6 second write to rst_en ignored", rd, 8'h00);
    wreg(8'h02, 8'h02);
    chk("R6 safe_en still writable", rd, 8'h02);
    wreg(8'h02, 8'h00);
    chk("R6 safe_en locked", rd, 8'h02);
    den = 0; lv = 1; tick();
    chk("R2 no set while disabled", rd, 8'h02);
    den = 1; lv = 1; tick(); den = 0; lv = 0; tick();
    chk("R2 flag sticky", rd, 8'h82);
    chk("R5 no reset request with rst_en 0", {7'b0, rrq}, 8'h00);
    wreg(8'h04, 8'h04);
    chk("R4 irq with int_en", {7'b0, irq}, 8'h01);
    den = 1; lv = 1; wreg(8'h40, 8'h40); den = 0; lv = 0;
    chk("R3 set wins over ack", rd, 8'h86);
    wreg(8'h40, 8'h40);
    chk("R3 ack clears flag", rd, 8'h06);
    chk("R4 irq drops", {7'b0, irq}, 8'h00);
    stp = 1; brm = 1; wrq = 1; tick();
    chk("R9 wake blocked", {6'b0, blk, wk}, 8'h02);
    brm = 0; tick();
    chk("R9 wake passes above re-arm", {6'b0, blk, wk}, 8'h01);
    stp = 0; wrq = 0;
    rst = 1; tick(); rst = 0; tick();
    chk("R8 general reset keeps rst_en 0", rd, 8'h00);
    wreg(8'h01, 8'h01);
    chk("R8 lock cleared by general reset", rd, 8'h01);
    den = 1; lv = 1; tick(); den = 0; lv = 0;
    chk("R5 reset request", {7'b0, rrq}, 8'h01);
    rst = 1; tick(); rst = 0; tick();
    chk("R8 reset clears flag keeps rst_en 1", rd, 8'h01);
    wreg(8'h01, 8'h00);
    por = 1; rst = 1; tick(); idle(); tick();
    chk("R8 power-on wins over general reset", rd, 8'h01);

    for (int i = 0; i < 4000; i++) begin
      por = ($urandom % 300) == 0;
      rst = ($urandom % 120) == 0;
      den = ($urandom % 4) != 0;
      lv  = ($urandom % 10) == 0;
      brm = $urandom % 2;
      stp = $urandom % 2;
      wrq = $urandom % 2;
      wr  = ($urandom % 3) == 0;
      wm  = 8'($urandom);
      wd  = 8'($urandom);
      tick();
    end
    idle(); tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule